// File: doc/BRIEF.md
# UART Baud Generator with Per-Bit Jitter

This block produces the timing skeleton of one UART frame for a transmit or receive shifter: a 16x oversampling tick, a strobe marking the end of each bit period, the index of the bit in progress and a strobe on the last bit of the frame. The base bit width comes from an 8-bit divisor held as "divisor minus one", so each oversampling tick spans `div_m1 + 1` clock cycles and a plain bit spans sixteen ticks.

To reach rates that an integer divisor cannot hit, every bit position of the frame carries a 2-bit adjustment code. A code can lengthen its bit by one tick or shorten it by one tick, i.e. by one sixteenth of a baud. Spreading such adjustments over the frame keeps the accumulated error of the whole frame small. A transmitter and a receiver each instantiate their own copy with their own adjustment word and the same divisor. Frame length follows from the line settings: one start bit, 5 to 8 data bits, an optional parity bit and one or two stop bits.

A frame begins on the clock edge that samples `frame_start` while `enable` is high. The divisor, the adjustment word and the frame length are captured on that edge and hold for the whole frame.

Top module: `uart_baud_jitter`

## Requirements
- R1: After reset, and whenever no frame is running, `sample_tick`, `bit_end`, `frame_done` and `busy` are 0 and `bit_index` is 0.
- R2: While a frame runs, `sample_tick` is high for one cycle out of every `div_m1 + 1`; the first tick comes in the `div_m1 + 1`-th cycle after the edge that accepted the start.
- R3: A bit with adjustment code none lasts exactly 16 ticks; `bit_end` is high for one cycle, coinciding with the last tick of the bit.
- R4: Bit position i uses code `jitter_word[2i+1:2i]`: 2'b01 makes the bit 17 ticks long, 2'b10 makes it 15 ticks long, 2'b00 and 2'b11 leave it at 16 ticks.
- R5: Frame length is 1 + (`data_len_code` + 5) + `parity_en` + (`stop_code` + 1) bits; `bit_index` starts at 0 and advances after each `bit_end`; `frame_done` is high together with the `bit_end` of the last bit, after which `busy` drops and `bit_index` returns to 0.
- R6: Changes to `div_m1`, `jitter_word`, `data_len_code`, `parity_en` or `stop_code` during a frame have no effect on that frame's timing.
- R7: While `enable` is low all counters are cleared, no output strobe is produced and `frame_start` is ignored.
- R8: A `frame_start` accepted while a frame runs abandons it and begins a new frame at bit 0 with freshly captured settings.
- R9: With `div_m1` equal to 0, `sample_tick` is high on every cycle of a running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Baud reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Generator enable; low clears all state |
| frame_start | input | 1 | One-cycle pulse starting a frame |
| div_m1 | input | 8 | Cycles per oversampling tick minus one |
| jitter_word | input | 24 | Two-bit adjustment code per bit position, position 0 in the low bits |
| data_len_code | input | 2 | Data bit count minus five |
| parity_en | input | 1 | Frame carries a parity bit |
| stop_code | input | 1 | Stop bit count minus one |
| sample_tick | output | 1 | 16x oversampling tick |
| bit_end | output | 1 | Last cycle of the current bit period |
| bit_index | output | 4 | Position of the bit in progress |
| frame_done | output | 1 | Last cycle of the frame |
| busy | output | 1 | A frame is running |

## Verification
The bench targets bits whose codes stretch, shrink or use the spare code 2'b11; a design that swapped the two active codes or treated 2'b11 as an adjustment would put `bit_end` one tick off and the frame length check would show it. It also hits the smallest divisor, where a prescaler that skips its wrap would halve the tick rate, and the shortest and longest frames, where an off-by-one in length decoding would drop or add a whole bit. Mid-frame setting changes, restarts while busy and a disable pulse with a start held high catch designs that read live inputs, ignore a restart or let a start slip through while disabled.

// File: rtl/bjg_pkg.sv
// Shared definitions for the UART baud generator with per-bit jitter.
// Assumes a frame of at most 12 bit positions and 16 ticks per nominal bit.
package bjg_pkg;

    // Oversampling ticks in a bit without adjustment
    localparam int SUB_TICKS = 16;

    // Per-bit adjustment code; the spare code behaves as no adjustment
    typedef enum logic [1:0] {
        JIT_NONE    = 2'b00,
        JIT_STRETCH = 2'b01,
        JIT_SHRINK  = 2'b10,
        JIT_SPARE   = 2'b11
    } jit_code_e;

    // Bits in a frame: start + data + optional parity + stop
    function automatic logic [3:0] frame_bits(input logic [1:0] data_code,
                                              input logic       par_en,
                                              input logic       stop_sel);
        return 4'd1 + (4'd5 + {2'b00, data_code}) + {3'b000, par_en}
               + (4'd1 + {3'b000, stop_sel});
    endfunction

endpackage

// File: rtl/bjg_prescaler.sv
// Divides the clock down to the oversampling tick.
// Assumes div_m1 is stable while run is high (the caller holds a captured copy).
module bjg_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div_m1,
    output logic             tick
);

    logic [DIV_W-1:0] pre_cnt;

    // Count clock cycles within one tick, wrapping at the divisor
    always_ff @(posedge clk) begin
        if (!rst_n || clear || restart) begin
            pre_cnt <= '0;
        end else if (run) begin
            pre_cnt <= (pre_cnt == div_m1) ? '0 : pre_cnt + 1'b1;
        end
    end

    assign tick = run && (pre_cnt == div_m1);

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (div_m1 != '0) && !restart && !clear) |=> !tick);

endmodule

// File: rtl/bjg_bit_timer.sv
// Counts oversampling ticks within one bit and flags the end of the bit.
// The bit length is 16 ticks, one more for a stretch code, one less for a
// shrink code. Assumes code is stable between bit boundaries.
module bjg_bit_timer
    import bjg_pkg::*;
#(
    parameter int SUB = SUB_TICKS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       restart,
    input  logic       tick,
    input  logic [1:0] code,
    output logic       bit_end
);

    localparam int TCNT_W = $clog2(SUB + 2);

    logic [TCNT_W-1:0] tick_cnt;
    logic [TCNT_W-1:0] last_tick;

    // Index of the final tick of this bit, from the adjustment code
    always_comb begin
        unique case (jit_code_e'(code))
            JIT_STRETCH: last_tick = TCNT_W'(SUB);
            JIT_SHRINK:  last_tick = TCNT_W'(SUB - 2);
            default:     last_tick = TCNT_W'(SUB - 1);
        endcase
    end

    assign bit_end = tick && (tick_cnt == last_tick);

    // Count ticks inside the bit, back to zero at the boundary
    always_ff @(posedge clk) begin
        if (!rst_n || clear || restart) begin
            tick_cnt <= '0;
        end else if (tick) begin
            tick_cnt <= bit_end ? '0 : tick_cnt + 1'b1;
        end
    end

    // R3
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear && !restart) |=> $stable(tick_cnt));

    // R4
    tick_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt <= TCNT_W'(SUB));

endmodule

// File: rtl/bjg_frame_seq.sv
// Frame sequencer: captures the settings on a start, tracks the bit index,
// and flags the last bit. Assumes len_in lies between 1 and MAX_BITS.
module bjg_frame_seq #(
    parameter int MAX_BITS = 12,
    parameter int DIV_W    = 8,
    parameter int IDX_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  start,
    input  logic [DIV_W-1:0]      div_in,
    input  logic [2*MAX_BITS-1:0] jit_in,
    input  logic [IDX_W-1:0]      len_in,
    input  logic                  bit_end,
    output logic                  busy,
    output logic [IDX_W-1:0]      bit_idx,
    output logic [DIV_W-1:0]      div_q,
    output logic [1:0]            code_cur,
    output logic                  frame_done
);

    logic [2*MAX_BITS-1:0] jit_q;
    logic [IDX_W-1:0]      len_q;

    assign frame_done = busy && bit_end && (bit_idx == (len_q - IDX_W'(1)));
    assign code_cur   = jit_q[2*int'(bit_idx) +: 2];

    // Run state and bit position through the frame
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            busy    <= 1'b0;
            bit_idx <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            bit_idx <= '0;
        end else if (frame_done) begin
            busy    <= 1'b0;
            bit_idx <= '0;
        end else if (busy && bit_end) begin
            bit_idx <= bit_idx + 1'b1;
        end
    end

    // Hold the frame settings from the accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            jit_q <= '0;
            len_q <= IDX_W'(1);
        end else if (start) begin
            div_q <= div_in;
            jit_q <= jit_in;
            len_q <= len_in;
        end
    end

    // R5
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bit_idx < len_q));

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !start && !clear) |=> (!busy && bit_idx == '0));

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> ($stable(div_q) && $stable(jit_q) && $stable(len_q)));

endmodule

// File: rtl/uart_baud_jitter.sv
// UART baud generator with per-bit jitter: oversampling tick, bit boundary,
// bit index and end of frame for one direction of a UART.
// Assumes frame_start is a single-cycle pulse; enable low acts as a clear.
module uart_baud_jitter #(
    parameter int DIV_W    = 8,
    parameter int MAX_BITS = 12,
    parameter int IDX_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  frame_start,
    input  logic [DIV_W-1:0]      div_m1,
    input  logic [2*MAX_BITS-1:0] jitter_word,
    input  logic [1:0]            data_len_code,
    input  logic                  parity_en,
    input  logic                  stop_code,
    output logic                  sample_tick,
    output logic                  bit_end,
    output logic [IDX_W-1:0]      bit_index,
    output logic                  frame_done,
    output logic                  busy
);

    logic             start_acc;
    logic             clr;
    logic [IDX_W-1:0] frame_len;
    logic [DIV_W-1:0] div_cap;
    logic [1:0]       cur_code;

    assign start_acc = enable && frame_start;
    assign clr       = !enable;
    assign frame_len = IDX_W'(bjg_pkg::frame_bits(data_len_code, parity_en, stop_code));

    bjg_frame_seq #(
        .MAX_BITS (MAX_BITS),
        .DIV_W    (DIV_W),
        .IDX_W    (IDX_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clr),
        .start      (start_acc),
        .div_in     (div_m1),
        .jit_in     (jitter_word),
        .len_in     (frame_len),
        .bit_end    (bit_end),
        .busy       (busy),
        .bit_idx    (bit_index),
        .div_q      (div_cap),
        .code_cur   (cur_code),
        .frame_done (frame_done)
    );

    bjg_prescaler #(
        .DIV_W (DIV_W)
    ) pre_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clr),
        .restart (start_acc),
        .run     (busy),
        .div_m1  (div_cap),
        .tick    (sample_tick)
    );

    bjg_bit_timer #(
        .SUB (bjg_pkg::SUB_TICKS)
    ) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clr),
        .restart (start_acc),
        .tick    (sample_tick),
        .code    (cur_code),
        .bit_end (bit_end)
    );

    // R3
    end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |-> sample_tick);

    // R5
    done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> bit_end);

    // R7
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !sample_tick && !frame_done));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sample_tick && !bit_end && bit_index == '0));

endmodule

// File: tb/uart_baud_jitter_tb_top.sv
// Bench: a behavioural cycle-count model compared with the design every cycle,
// plus directed frames whose total length is checked end to end.
module uart_baud_jitter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        frame_start = 1'b0;
    logic [7:0]  div_m1 = 8'd0;
    logic [23:0] jitter_word = 24'd0;
    logic [1:0]  data_len_code = 2'd0;
    logic        parity_en = 1'b0;
    logic        stop_code = 1'b0;
    logic        sample_tick, bit_end, frame_done, busy;
    logic [3:0]  bit_index;

    int total = 0;
    int bad = 0;
    int wd = 0;
    bit cmp_on = 1'b0;
    string scen = "R1";

    // reference model state
    int    m_busy = 0, m_cyc = 0, m_bit = 0, m_div = 0, m_len = 1;
    logic [23:0] m_jit = '0;

    uart_baud_jitter dut_i (
        .clk (clk), .rst_n (rst_n), .enable (enable), .frame_start (frame_start),
        .div_m1 (div_m1), .jitter_word (jitter_word), .data_len_code (data_len_code),
        .parity_en (parity_en), .stop_code (stop_code), .sample_tick (sample_tick),
        .bit_end (bit_end), .bit_index (bit_index), .frame_done (frame_done), .busy (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ticks_of(input logic [1:0] c);
        if (c == 2'b01) return 17;
        if (c == 2'b10) return 15;
        return 16;
    endfunction

    function automatic int len_of(input logic [1:0] d, input logic p, input logic s);
        return 1 + (int'(d) + 5) + int'(p) + (int'(s) + 1);
    endfunction

    function automatic int frame_cycles(input int dv, input logic [23:0] jw, input int ln);
        int sum = 0;
        for (int i = 0; i < ln; i++) sum += ticks_of(jw[2*i +: 2]);
        return sum * (dv + 1);
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s [%s] t=%0t act=%0d exp=%0d", tag, scen, $time, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // reference model: advance by one clock using the inputs at this edge
    always @(posedge clk) begin
        if (!rst_n || !enable) begin
            m_busy = 0; m_cyc = 0; m_bit = 0;
        end else if (frame_start) begin
            m_busy = 1; m_cyc = 0; m_bit = 0;
            m_div = int'(div_m1); m_jit = jitter_word;
            m_len = len_of(data_len_code, parity_en, stop_code);
        end else if (m_busy != 0) begin
            if (m_cyc == ticks_of(m_jit[2*m_bit +: 2]) * (m_div + 1) - 1) begin
                m_cyc = 0;
                if (m_bit == m_len - 1) begin m_busy = 0; m_bit = 0; end
                else m_bit++;
            end else m_cyc++;
        end
    end

    // compare design outputs with the model away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            int e_tick, e_end, e_done;
            e_tick = (m_busy != 0 && ((m_cyc + 1) % (m_div + 1)) == 0) ? 1 : 0;
            e_end  = (m_busy != 0 &&
                      m_cyc == ticks_of(m_jit[2*m_bit +: 2]) * (m_div + 1) - 1) ? 1 : 0;
            e_done = (e_end != 0 && m_bit == m_len - 1) ? 1 : 0;
            chk(int'(sample_tick), e_tick, "R2 sample_tick");
            chk(int'(bit_end), e_end, "R3 bit_end");
            chk(int'(bit_index), m_bit, "R5 bit_index");
            chk(int'(frame_done), e_done, "R5 frame_done");
            chk(int'(busy), m_busy, "R5 busy");
        end
    end

    // watchdog
    always @(posedge clk) begin
        wd++;
        if (wd > WD_LIMIT) begin
            bad++;
            $display("FAIL watchdog expired [%s]", scen);
            finish_run();
        end
    end

    // start a frame and measure cycles until frame_done; optionally disturb
    // the settings a few cycles in
    task automatic run_frame(input int dv, input logic [23:0] jw, input logic [1:0] dc,
                             input logic p, input logic s, input bit disturb, input string tag);
        int cyc = 0;
        int exp_n;
        exp_n = frame_cycles(dv, jw, len_of(dc, p, s));
        @(negedge clk);
        div_m1 = 8'(dv); jitter_word = jw; data_len_code = dc; parity_en = p; stop_code = s;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        while (!frame_done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (disturb && cyc == 5) begin
                div_m1 = 8'd200; jitter_word = 24'hAAAAAA;
                data_len_code = ~dc; parity_en = ~p; stop_code = ~s;
            end
        end
        chk(cyc, exp_n - 1, tag);
        @(negedge clk);
        chk(int'(busy), 0, "R5 idle after frame");
        chk(int'(bit_index), 0, "R5 index back to 0");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(int'(sample_tick), 0, "R1 tick");
        chk(int'(bit_end), 0, "R1 bit_end");
        chk(int'(frame_done), 0, "R1 done");
        chk(int'(busy), 0, "R1 busy");
        chk(int'(bit_index), 0, "R1 index");
        cmp_on = 1'b1;
        enable = 1'b1;
        repeat (3) @(negedge clk);

        // R9: smallest divisor, 8N1
        scen = "R9";
        run_frame(0, 24'h000000, 2'd3, 1'b0, 1'b0, 1'b0, "R9 frame length div0");

        // R3: nominal bits, 5N1 shortest frame
        scen = "R3";
        run_frame(2, 24'h000000, 2'd0, 1'b0, 1'b0, 1'b0, "R3 nominal frame");

        // R4: mixed stretch/shrink/spare codes, 8E2 longest frame
        scen = "R4";
        run_frame(3, 24'h800179, 2'd3, 1'b1, 1'b1, 1'b0, "R4 jitter frame");
        run_frame(1, 24'h555555, 2'd2, 1'b1, 1'b0, 1'b0, "R4 all stretch");
        run_frame(1, 24'hAAAAAA, 2'd1, 1'b0, 1'b1, 1'b0, "R4 all shrink");
        run_frame(0, 24'hFFFFFF, 2'd3, 1'b1, 1'b1, 1'b0, "R4 spare code");

        // R6: settings disturbed mid-frame
        scen = "R6";
        run_frame(2, 24'h000910, 2'd1, 1'b1, 1'b0, 1'b1, "R6 capture frame");

        // R8: restart while busy
        scen = "R8";
        @(negedge clk);
        div_m1 = 8'd4; jitter_word = 24'h0; data_len_code = 2'd3; parity_en = 1'b1; stop_code = 1'b1;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        repeat (120) @(negedge clk);
        chk(int'(busy), 1, "R8 busy before restart");
        run_frame(1, 24'h000006, 2'd0, 1'b0, 1'b0, 1'b0, "R8 restarted frame");

        // R7: disable mid-frame with start held high
        scen = "R7";
        @(negedge clk);
        div_m1 = 8'd2; data_len_code = 2'd3;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        repeat (30) @(negedge clk);
        enable = 1'b0;
        frame_start = 1'b1;
        repeat (3) @(negedge clk);
        chk(int'(busy), 0, "R7 busy while disabled");
        chk(int'(sample_tick), 0, "R7 tick while disabled");
        chk(int'(bit_index), 0, "R7 index while disabled");
        frame_start = 1'b0;
        enable = 1'b1;
        repeat (10) @(negedge clk);
        chk(int'(busy), 0, "R7 start ignored while disabled");
        run_frame(0, 24'h000001, 2'd2, 1'b0, 1'b1, 1'b0, "R7 frame after enable");

        repeat (5) @(negedge clk);
        cmp_on = 1'b0;
        finish_run();
    end

endmodule